// File: doc/BRIEF.md
# SPI Controller Interrupt Aggregator

This block gathers the interrupt sources of an SPI controller into one status register and turns them into a single level-sensitive interrupt line. Some sources are single-cycle event pulses from the shifting logic: a completed transmit drain, transmit underrun, receive FIFO becoming full, receive overrun and transmit FIFO half empty. Two others are live FIFO levels: receive FIFO holding data and receive FIFO full. These levels are folded into the status register whenever the register file is accessed or an event arrives.

Software sees three 32-bit registers on a word-addressed bus: a global gate, the status register and a per-bit enable register. A write to the status register flips every defined bit that is written as one. This is a toggle rule, not clear-on-one. The interrupt output is registered. It follows the gate, status and enable values that are loaded at the same clock edge, so it never glitches while being recomputed.

Top module: `spi_irq_agg`

## Requirements
- R1: Synchronous reset clears the gate, status and enable registers and drives `irq` low.
- R2: Registers sit at word addresses 7 (gate, byte 0x1C), 8 (status, byte 0x20) and 10 (enable, byte 0x28). A read returns the value held before that cycle's update on `bus_rdata` one clock after `bus_rd`. A read of any other address returns zero.
- R3: The gate register keeps only bit 31; its other bits read as zero. The enable register keeps all 32 bits.
- R4: Status bits are drain-empty = 2, underrun = 3, rx-full = 4, overrun = 5, half-empty = 6 and rx-not-empty = 8 (mask 0x17C). A status write XORs the written data into these bits. All other bits read zero.
- R5: `ev_tx_drained` sets bits 2 and 8, `ev_tx_underrun` sets bit 3, `ev_rx_full` sets bit 4, `ev_rx_overrun` sets bit 5 and `ev_tx_half` sets bit 6.
- R6: In a cycle with any bus read, bus write or event pulse, `lv_rx_nonempty` sets bit 8 and `lv_rx_full` sets bit 4. Levels never clear a bit, and they have no effect in idle cycles.
- R7: When an event pulse and a status toggle hit the same bit in one cycle, the bit ends set.
- R8: `irq` is high exactly when gate bit 31 is set and (status AND enable) is nonzero. It is registered and changes at the same edge as the register update that causes it, and it stays steady in cycles with no access and no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| ev_tx_drained | input | 1 | Pulse: transmit FIFO drained |
| ev_tx_underrun | input | 1 | Pulse: transmit underrun |
| ev_rx_full | input | 1 | Pulse: receive FIFO became full |
| ev_rx_overrun | input | 1 | Pulse: receive overrun |
| ev_tx_half | input | 1 | Pulse: transmit FIFO half empty |
| lv_rx_nonempty | input | 1 | Level: receive FIFO holds data |
| lv_rx_full | input | 1 | Level: receive FIFO is full |
| irq | output | 1 | Level interrupt output |

## Verification
The assertions assume each event input is a clean pulse sampled on the clock edge. They also assume `bus_wr` and `bus_rd` are never raised together, so at most one register operation happens per cycle. The stimulus changes inputs only on falling edges and issues one operation per vector. It raises the FIFO level inputs both in idle cycles and during accesses, so that forcing can be told apart from holding. Same-cycle collisions between a toggle write and an event are placed on a bit that is already set, which is where the two rules disagree.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  // Byte offsets of the software-visible registers
  localparam int OFS_GATE_B = 'h1C;
  localparam int OFS_STAT_B = 'h20;
  localparam int OFS_ENAB_B = 'h28;

  localparam int NREG     = 3;
  localparam int IDX_GATE = 0;
  localparam int IDX_STAT = 1;
  localparam int IDX_ENAB = 2;

  // Status bit positions
  localparam int B_DRAIN = 2;
  localparam int B_UNDER = 3;
  localparam int B_RXFUL = 4;
  localparam int B_OVRUN = 5;
  localparam int B_HALF  = 6;
  localparam int B_RXNE  = 8;

  function automatic int word_ofs(input int idx);
    case (idx)
      IDX_GATE: return OFS_GATE_B / 4;
      IDX_STAT: return OFS_STAT_B / 4;
      default:  return OFS_ENAB_B / 4;
    endcase
  endfunction
endpackage

// File: rtl/spi_irq_decode.sv
module spi_irq_decode
  import spi_irq_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   hit
);
  for (genvar g = 0; g < NREG; g++) begin : g_cmp
    localparam logic [ADDR_W-1:0] WOFS = ADDR_W'(word_ofs(g));
    assign hit[g] = (addr == WOFS);
  end
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
  import spi_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stat,
  input  logic [DATA_W-1:0] wdata,
  input  logic              touch,
  input  logic [DATA_W-1:0] set_vec,
  input  logic              lvl_ne,
  input  logic              lvl_full,
  output logic [DATA_W-1:0] stat_d,
  output logic [DATA_W-1:0] stat_q
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);
  localparam logic [DATA_W-1:0] MASK =
    (ONE << B_DRAIN) | (ONE << B_UNDER) | (ONE << B_RXFUL) |
    (ONE << B_OVRUN) | (ONE << B_HALF)  | (ONE << B_RXNE);

  always_comb begin
    stat_d = stat_q;
    if (wr_stat) stat_d = stat_d ^ (wdata & MASK);
    // events are applied after the toggle so they win a collision
    stat_d = stat_d | (set_vec & MASK);
    if (touch) begin
      stat_d[B_RXNE]  = stat_d[B_RXNE]  | lvl_ne;
      stat_d[B_RXFUL] = stat_d[B_RXFUL] | lvl_full;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= stat_d;
  end
endmodule

// File: rtl/spi_irq_output.sv
module spi_irq_output #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gate_d,
  input  logic [DATA_W-1:0] stat_d,
  input  logic [DATA_W-1:0] enab_d,
  output logic              irq_q
);
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= gate_d & (|(stat_d & enab_d));
  end
endmodule

// File: rtl/spi_irq_agg.sv
module spi_irq_agg
  import spi_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ev_tx_drained,
  input  logic              ev_tx_underrun,
  input  logic              ev_rx_full,
  input  logic              ev_rx_overrun,
  input  logic              ev_tx_half,
  input  logic              lv_rx_nonempty,
  input  logic              lv_rx_full,
  output logic              irq
);
  localparam int GATE_BIT = DATA_W - 1;

  logic [NREG-1:0]   hit;
  logic              wr_gate, wr_stat, wr_enab, any_ev, touch;
  logic [DATA_W-1:0] set_vec, stat_d, stat_q, enab_d, enab_q;
  logic              gate_d, gate_q;

  spi_irq_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .hit  (hit)
  );

  assign wr_gate = bus_wr & hit[IDX_GATE];
  assign wr_stat = bus_wr & hit[IDX_STAT];
  assign wr_enab = bus_wr & hit[IDX_ENAB];
  assign any_ev  = ev_tx_drained | ev_tx_underrun | ev_rx_full |
                   ev_rx_overrun | ev_tx_half;
  assign touch   = bus_wr | bus_rd | any_ev;

  always_comb begin
    set_vec          = '0;
    set_vec[B_DRAIN] = ev_tx_drained;
    set_vec[B_RXNE]  = ev_tx_drained;
    set_vec[B_UNDER] = ev_tx_underrun;
    set_vec[B_RXFUL] = ev_rx_full;
    set_vec[B_OVRUN] = ev_rx_overrun;
    set_vec[B_HALF]  = ev_tx_half;
  end

  spi_irq_status #(.DATA_W(DATA_W)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .wr_stat  (wr_stat),
    .wdata    (bus_wdata),
    .touch    (touch),
    .set_vec  (set_vec),
    .lvl_ne   (lv_rx_nonempty),
    .lvl_full (lv_rx_full),
    .stat_d   (stat_d),
    .stat_q   (stat_q)
  );

  assign gate_d = wr_gate ? bus_wdata[GATE_BIT] : gate_q;
  assign enab_d = wr_enab ? bus_wdata : enab_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= 1'b0;
      enab_q <= '0;
    end else begin
      gate_q <= gate_d;
      enab_q <= enab_d;
    end
  end

  spi_irq_output #(.DATA_W(DATA_W)) u_out (
    .clk    (clk),
    .rst    (rst),
    .gate_d (gate_d),
    .stat_d (stat_d),
    .enab_d (enab_d),
    .irq_q  (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (hit[IDX_GATE])      bus_rdata <= {gate_q, {(DATA_W-1){1'b0}}};
      else if (hit[IDX_STAT]) bus_rdata <= stat_q;
      else if (hit[IDX_ENAB]) bus_rdata <= enab_q;
      else                    bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/spi_irq_agg_chk.sv
module spi_irq_agg_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              ev_tx_drained,
  input logic              ev_tx_underrun,
  input logic              ev_rx_full,
  input logic              ev_rx_overrun,
  input logic              ev_tx_half,
  input logic              lv_rx_nonempty,
  input logic              irq,
  input logic [DATA_W-1:0] stat_q,
  input logic [DATA_W-1:0] enab_q,
  input logic              gate_q
);
  logic rst_seen = 1'b0;
  logic quiet;
  assign quiet = !(bus_wr | bus_rd | ev_tx_drained | ev_tx_underrun |
                   ev_rx_full | ev_rx_overrun | ev_tx_half);

  always @(posedge clk) begin
    if (rst_seen) begin
      a_r1_reset_clear: assert (!irq && stat_q == '0 && enab_q == '0 && !gate_q);
    end
    rst_seen <= rst;
  end

  a_r5_drain_sets: assert property (@(posedge clk) disable iff (rst)
    ev_tx_drained |=> (stat_q[2] && stat_q[8]));

  a_r7_overrun_wins: assert property (@(posedge clk) disable iff (rst)
    ev_rx_overrun |=> stat_q[5]);

  a_r6_level_forces: assert property (@(posedge clk) disable iff (rst)
    (!quiet && lv_rx_nonempty) |=> stat_q[8]);

  a_r6_idle_holds: assert property (@(posedge clk) disable iff (rst)
    quiet |=> $stable(stat_q));

  a_r8_gate_off_low: assert property (@(posedge clk) disable iff (rst)
    !gate_q |-> !irq);

  a_r8_needs_source: assert property (@(posedge clk) disable iff (rst)
    irq |-> (|(stat_q & enab_q)));

  a_r8_steady_idle: assert property (@(posedge clk) disable iff (rst)
    quiet |=> $stable(irq));
endmodule

bind spi_irq_agg spi_irq_agg_chk #(.DATA_W(DATA_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .bus_wr         (bus_wr),
  .bus_rd         (bus_rd),
  .ev_tx_drained  (ev_tx_drained),
  .ev_tx_underrun (ev_tx_underrun),
  .ev_rx_full     (ev_rx_full),
  .ev_rx_overrun  (ev_rx_overrun),
  .ev_tx_half     (ev_tx_half),
  .lv_rx_nonempty (lv_rx_nonempty),
  .irq            (irq),
  .stat_q         (stat_q),
  .enab_q         (enab_q),
  .gate_q         (gate_q)
);

// File: tb/spi_irq_agg_tb.sv
module spi_irq_agg_tb;
  localparam int DW = 32;
  localparam int AW = 5;
  localparam int VW = 83;
  localparam int NV = 32;
  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_EV = 2'd2;
  localparam logic [4:0] A_G = 5'd7, A_S = 5'd8, A_E = 5'd10;
  // ev: [0] drained [1] underrun [2] rx_full [3] overrun [4] half ; lv: [1] full [0] nonempty

  function automatic logic [VW-1:0] v(input int req, input logic [1:0] k,
      input logic [4:0] a, input logic [31:0] d, input logic [4:0] ev,
      input logic [1:0] lv, input logic ei, input logic [31:0] er);
    return {4'(req), k, a, d, ev, lv, ei, er};
  endfunction

  localparam logic [VW-1:0] VEC [NV] = '{
    v(1, K_RD, A_S, 0, 0, 0, 0, 32'h0),             // R1 status zero
    v(1, K_RD, A_G, 0, 0, 0, 0, 32'h0),             // R1 gate zero
    v(3, K_WR, A_E, 32'hFFFF_FFFF, 0, 0, 0, 0),     // R3 enable all
    v(3, K_RD, A_E, 0, 0, 0, 0, 32'hFFFF_FFFF),     // R3 all bits kept
    v(8, K_WR, A_G, 32'hFFFF_FFFF, 0, 0, 0, 0),     // R8 gate on, no source
    v(3, K_RD, A_G, 0, 0, 0, 0, 32'h8000_0000),     // R3 only bit 31
    v(5, K_EV, 0, 0, 5'b00001, 0, 1, 0),            // R5 drain -> irq
    v(5, K_RD, A_S, 0, 0, 0, 1, 32'h104),           // R5 bits 2 and 8
    v(4, K_WR, A_S, 32'h104, 0, 0, 0, 0),           // R4 toggle off
    v(4, K_RD, A_S, 0, 0, 0, 0, 32'h0),             // R4
    v(4, K_WR, A_S, 32'hFFFF_FFFF, 0, 0, 1, 0),     // R4 toggle all
    v(4, K_RD, A_S, 0, 0, 0, 1, 32'h17C),           // R4 mask only
    v(4, K_WR, A_S, 32'h17C, 0, 0, 0, 0),           // R4 back to zero
    v(8, K_WR, A_E, 32'h20, 0, 0, 0, 0),            // R8 enable overrun only
    v(8, K_EV, 0, 0, 5'b00010, 0, 0, 0),            // R8 underrun masked
    v(5, K_EV, 0, 0, 5'b01000, 0, 1, 0),            // R5 overrun -> irq
    v(8, K_WR, A_G, 32'h0, 0, 0, 0, 0),             // R8 gate off
    v(2, K_RD, A_G, 0, 0, 0, 0, 32'h0),             // R2 gate reads back
    v(8, K_WR, A_G, 32'h8000_0000, 0, 0, 1, 0),     // R8 gate on
    v(4, K_WR, A_S, 32'h28, 0, 0, 0, 0),            // R4 clear 3,5
    v(6, K_EV, 0, 0, 0, 2'b11, 0, 0),               // R6 idle, no force
    v(6, K_RD, A_S, 0, 0, 2'b11, 0, 32'h0),         // R6 old value, then forced
    v(6, K_RD, A_S, 0, 0, 2'b00, 0, 32'h110),       // R6 forced bits, not cleared
    v(8, K_WR, A_E, 32'h100, 0, 0, 1, 0),           // R8 enable rx-ne
    v(6, K_WR, A_S, 32'h100, 0, 2'b01, 1, 0),       // R6 level re-forces bit 8
    v(4, K_WR, A_S, 32'h110, 0, 0, 0, 0),           // R4 clear
    v(5, K_WR, A_S, 32'h40, 5'b10000, 0, 0, 0),     // R5 half sets bit 6
    v(7, K_WR, A_S, 32'h40, 5'b10000, 0, 0, 0),     // R7 event beats toggle
    v(7, K_RD, A_S, 0, 0, 0, 0, 32'h40),            // R7
    v(5, K_WR, A_S, 32'h40, 5'b00100, 0, 0, 0),     // R5 rx_full sets bit 4
    v(5, K_RD, A_S, 0, 0, 0, 0, 32'h10),            // R5
    v(2, K_RD, 5'd9, 0, 0, 0, 0, 32'h0)             // R2 unmapped reads zero
  };

  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 0, bus_rd = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  logic [4:0] ev = '0;
  logic [1:0] lv = '0;
  logic irq;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  spi_irq_agg #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_tx_drained(ev[0]), .ev_tx_underrun(ev[1]), .ev_rx_full(ev[2]),
    .ev_rx_overrun(ev[3]), .ev_tx_half(ev[4]),
    .lv_rx_nonempty(lv[0]), .lv_rx_full(lv[1]), .irq(irq)
  );

  task automatic check(input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic op(input logic w, input logic r, input logic [4:0] a,
                    input logic [31:0] d, input logic [4:0] e, input logic [1:0] l);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; ev = e; lv = l;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; ev = '0; lv = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    nchk++; nfail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    check(1, "irq after reset", 32'(irq), 0);   // R1
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] e;
      e = VEC[i];
      op(e[78:77] == K_WR, e[78:77] == K_RD, e[76:72], e[71:40], e[39:35], e[34:33]);
      check(int'(e[82:79]), $sformatf("vec %0d irq", i), 32'(irq), 32'(e[32]));
      if (e[78:77] == K_RD)
        check(int'(e[82:79]), $sformatf("vec %0d rdata", i), bus_rdata, e[31:0]);
    end
    // R1: reset in the middle of operation
    op(1, 0, A_E, 32'h100, 0, 0);
    op(1, 0, A_G, 32'h8000_0000, 0, 0);
    op(0, 0, 0, 0, 5'b00001, 0);
    check(8, "irq before reset", 32'(irq), 1);
    rst = 1;
    @(negedge clk);
    rst = 0;
    check(1, "irq after mid reset", 32'(irq), 0);
    op(0, 1, A_S, 0, 0, 0);
    check(1, "status after reset", bus_rdata, 0);
    op(0, 1, A_E, 0, 0, 0);
    check(1, "enable after reset", bus_rdata, 0);
    op(0, 1, A_G, 0, 0, 0);
    check(1, "gate after reset", bus_rdata, 0);
    finish_run();
  end
endmodule